// File: doc/BRIEF.md
# Paravirtual queue configuration register file

This block is the shared configuration register structure of a paravirtual PCI device. Software reaches it through a plain register port that carries a byte address, an access size and 64 bits of little-endian data. Each field must be accessed at its own width and offset. The structure holds the device's 64-bit feature word and the driver's 64-bit feature word, each seen through a 32-bit window that a select register picks. It also holds a device status byte and a configuration interrupt vector.

A queue-select register banks a group of per-queue fields. These are the queue size, the queue interrupt vector, the queue enable, a read-only notify offset, and the addresses of the descriptor table, the available ring and the used ring. Every field has its own rule for which written values it keeps. All per-queue state, the accepted driver features, the status byte and the configuration vector leave the block as plain outputs for the queue datapath.

Top module: `vq_cfg_regs`

## Requirements
- R1: Every access must match a field's exact offset and width (size code 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes). A write that misses is ignored, and a read that misses returns 0, as does a read of the unused byte at 0x15 or of any offset from 0x38 up. Read data appears on `rdata` in the cycle after `rd_en`, with the field in the low bits and byte 0 in bits 7:0.
- R2: The device feature select (0x00, 4 bytes) picks what the device feature field (0x04, 4 bytes) returns: value 0 gives feature bits 31:0, value 1 gives bits 63:32, and any other value gives 0.
- R3: The driver feature select (0x08, 4 bytes) picks the 32-bit half of the driver feature word that the driver feature field (0x0C, 4 bytes) reads and writes: 0 selects bits 31:0 and 1 selects bits 63:32. With any other select value, writes are dropped and reads return 0. The word is output on `drv_feat_o`.
- R4: The device feature field, the queue count (0x12, 2 bytes, reads NUM_Q) and the notify offset (0x1E, 2 bytes, reads the selected queue index) are read-only. Writes to them change nothing.
- R5: Each queue size (0x18, 2 bytes) resets to MAX_QSIZE. A write is kept only if the value is 0 or a power of two no larger than MAX_QSIZE. Any other value leaves the previous size in place.
- R6: Each queue enable (0x1C, 2 bytes) resets to 0. Only the values 0 and 1 are accepted; other values are dropped.
- R7: The configuration vector (0x10, 2 bytes) and each queue vector (0x1A, 2 bytes) reset to 0xFFFF. A written value below VEC_TBL is stored. Any larger value stores 0xFFFF.
- R8: The queue select (0x16, 2 bytes) picks the queue that offsets 0x18 to 0x37 refer to. When the select is at or beyond NUM_Q, all per-queue fields read 0 and ignore writes.
- R9: The descriptor table (0x20), available ring (0x28) and used ring (0x30) addresses are 8-byte fields held separately for each queue.
- R10: The device status (0x14, 1 byte) stores the written byte. Writing 0 returns every feature, select, vector, status and queue register to its reset value.
- R11: The per-queue outputs show each queue's state in queue-index order, 16 or 64 bits per queue (the enable uses one bit per queue). The outputs change only in the cycle after an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address of the access |
| size | input | 2 | Access size code |
| wdata | input | 64 | Write data, little-endian, field in low bits |
| rdata | output | 64 | Read data, valid the cycle after rd_en |
| drv_feat_o | output | 64 | Driver-accepted feature word |
| dev_status_o | output | 8 | Device status byte |
| cfg_vec_o | output | 16 | Configuration change interrupt vector |
| q_size_o | output | 16*NUM_Q | Per-queue size |
| q_vec_o | output | 16*NUM_Q | Per-queue interrupt vector |
| q_en_o | output | NUM_Q | Per-queue enable |
| q_desc_o | output | 64*NUM_Q | Per-queue descriptor table address |
| q_avail_o | output | 64*NUM_Q | Per-queue available ring address |
| q_used_o | output | 64*NUM_Q | Per-queue used ring address |

## Verification
The bench steers both feature selects past 1. A design that only decoded bit 0 of the select would alias select 7 onto the upper window and corrupt the driver word. It offers queue sizes of 100 and 512 and an oversized vector of 64. A design that stored them unchecked would hand the datapath a ring size that is not a power of two, or an interrupt entry past the end of the table. It moves the queue select to 5 and then writes a size there; a design that truncated the index would clobber queue 1. It also makes wrong-width and half-width accesses and finally writes a zero status, which must bring every bank, vector and select back to its reset value.

// File: rtl/vq_cfg_pkg.sv
package vq_cfg_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_DWORD = 2'd3
   } acc_sz_e;

   typedef enum logic [4:0] {
      F_NONE, F_DFSEL, F_DFEAT, F_GFSEL, F_GFEAT, F_CVEC, F_NUMQ, F_STAT,
      F_QSEL, F_QSIZE, F_QVEC, F_QEN, F_QNOFF, F_QDESC, F_QAVAIL, F_QUSED
   } fld_e;

   localparam logic [15:0] NO_VECTOR = 16'hFFFF;
   localparam logic [5:0]  STAT_OFF  = 6'h14;

   // offset and width must both match; anything else decodes to nothing
   function automatic fld_e decode_fld(input logic [5:0] a, input logic [1:0] sz);
      fld_e f;
      case ({a, sz})
         {6'h00, SZ_WORD}:  f = F_DFSEL;
         {6'h04, SZ_WORD}:  f = F_DFEAT;
         {6'h08, SZ_WORD}:  f = F_GFSEL;
         {6'h0C, SZ_WORD}:  f = F_GFEAT;
         {6'h10, SZ_HALF}:  f = F_CVEC;
         {6'h12, SZ_HALF}:  f = F_NUMQ;
         {STAT_OFF, SZ_BYTE}: f = F_STAT;
         {6'h16, SZ_HALF}:  f = F_QSEL;
         {6'h18, SZ_HALF}:  f = F_QSIZE;
         {6'h1A, SZ_HALF}:  f = F_QVEC;
         {6'h1C, SZ_HALF}:  f = F_QEN;
         {6'h1E, SZ_HALF}:  f = F_QNOFF;
         {6'h20, SZ_DWORD}: f = F_QDESC;
         {6'h28, SZ_DWORD}: f = F_QAVAIL;
         {6'h30, SZ_DWORD}: f = F_QUSED;
         default:           f = F_NONE;
      endcase
      return f;
   endfunction

   function automatic logic [15:0] map_vec(input logic [15:0] w, input int tbl);
      return (32'(w) < tbl) ? w : NO_VECTOR;
   endfunction

   function automatic logic qsize_ok(input logic [15:0] w, input int max_sz);
      return (w == 16'd0) || (($countones(w) == 1) && (32'(w) <= max_sz));
   endfunction

endpackage

// File: rtl/vq_access_dec.sv
module vq_access_dec
   import vq_cfg_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   output fld_e              fld
);

   logic hi_zero;

   generate
      if (ADDR_W > 6) begin : g_wide
         assign hi_zero = ~|addr[ADDR_W-1:6];
      end else begin : g_exact
         assign hi_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      fld = hi_zero ? decode_fld(addr[5:0], size) : F_NONE;
   end

endmodule

// File: rtl/vq_feat_win.sv
module vq_feat_win #(
   parameter logic [63:0] DEV_FEAT = 64'h0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        wr_dsel,
   input  logic        wr_gsel,
   input  logic        wr_gfeat,
   input  logic [31:0] wdata,
   output logic [31:0] dsel_q,
   output logic [31:0] gsel_q,
   output logic [31:0] dfeat_rd,
   output logic [31:0] gfeat_rd,
   output logic [63:0] drv_feat_o
);

   localparam int N_WORDS = 2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dsel_q <= '0;
         gsel_q <= '0;
      end else if (clr) begin
         dsel_q <= '0;
         gsel_q <= '0;
      end else begin
         if (wr_dsel) dsel_q <= wdata;
         if (wr_gsel) gsel_q <= wdata;
      end
   end

   genvar w;
   generate
      for (w = 0; w < N_WORDS; w++) begin : g_word
         logic [31:0] word_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               word_q <= '0;
            else if (clr)
               word_q <= '0;
            else if (wr_gfeat && (gsel_q == 32'(w)))
               word_q <= wdata;
         end
         assign drv_feat_o[32*w +: 32] = word_q;
      end
   endgenerate

   always_comb begin
      case (dsel_q)
         32'd0:   dfeat_rd = DEV_FEAT[31:0];
         32'd1:   dfeat_rd = DEV_FEAT[63:32];
         default: dfeat_rd = '0;
      endcase
      case (gsel_q)
         32'd0:   gfeat_rd = drv_feat_o[31:0];
         32'd1:   gfeat_rd = drv_feat_o[63:32];
         default: gfeat_rd = '0;
      endcase
   end

endmodule

// File: rtl/vq_queue_bank.sv
module vq_queue_bank
   import vq_cfg_pkg::*;
#(
   parameter int NUM_Q     = 4,
   parameter int MAX_QSIZE = 256,
   parameter int VEC_TBL   = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic [15:0]          qsel,
   input  logic                 wr_size,
   input  logic                 wr_vec,
   input  logic                 wr_en,
   input  logic                 wr_desc,
   input  logic                 wr_avail,
   input  logic                 wr_used,
   input  logic [63:0]          wdata,
   output logic [15:0]          sel_size,
   output logic [15:0]          sel_vec,
   output logic [15:0]          sel_en,
   output logic [15:0]          sel_noff,
   output logic [63:0]          sel_desc,
   output logic [63:0]          sel_avail,
   output logic [63:0]          sel_used,
   output logic [16*NUM_Q-1:0]  q_size_o,
   output logic [16*NUM_Q-1:0]  q_vec_o,
   output logic [NUM_Q-1:0]     q_en_o,
   output logic [64*NUM_Q-1:0]  q_desc_o,
   output logic [64*NUM_Q-1:0]  q_avail_o,
   output logic [64*NUM_Q-1:0]  q_used_o
);

   localparam int          QI_W     = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
   localparam logic [15:0] SIZE_RST = 16'(MAX_QSIZE);

   logic            sel_ok;
   logic [QI_W-1:0] idx;
   logic [15:0]     w16;
   logic            size_acc;
   logic            en_acc;
   logic [15:0]     vec_new;

   assign sel_ok   = (32'(qsel) < NUM_Q);
   assign idx      = qsel[QI_W-1:0];
   assign w16      = wdata[15:0];
   assign size_acc = qsize_ok(w16, MAX_QSIZE);
   assign en_acc   = (w16 <= 16'd1);
   assign vec_new  = map_vec(w16, VEC_TBL);

   genvar q;
   generate
      for (q = 0; q < NUM_Q; q++) begin : g_q
         logic        hit;
         logic [15:0] size_q;
         logic [15:0] vec_q;
         logic        en_q;
         logic [63:0] desc_q;
         logic [63:0] avail_q;
         logic [63:0] used_q;

         assign hit = sel_ok && (idx == QI_W'(q));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               size_q  <= SIZE_RST;
               vec_q   <= NO_VECTOR;
               en_q    <= 1'b0;
               desc_q  <= '0;
               avail_q <= '0;
               used_q  <= '0;
            end else if (clr) begin
               size_q  <= SIZE_RST;
               vec_q   <= NO_VECTOR;
               en_q    <= 1'b0;
               desc_q  <= '0;
               avail_q <= '0;
               used_q  <= '0;
            end else if (hit) begin
               if (wr_size && size_acc) size_q  <= w16;
               if (wr_vec)              vec_q   <= vec_new;
               if (wr_en && en_acc)     en_q    <= w16[0];
               if (wr_desc)             desc_q  <= wdata;
               if (wr_avail)            avail_q <= wdata;
               if (wr_used)             used_q  <= wdata;
            end
         end

         assign q_size_o[16*q +: 16]  = size_q;
         assign q_vec_o[16*q +: 16]   = vec_q;
         assign q_en_o[q]             = en_q;
         assign q_desc_o[64*q +: 64]  = desc_q;
         assign q_avail_o[64*q +: 64] = avail_q;
         assign q_used_o[64*q +: 64]  = used_q;
      end
   endgenerate

   always_comb begin
      sel_size  = '0;
      sel_vec   = '0;
      sel_en    = '0;
      sel_noff  = '0;
      sel_desc  = '0;
      sel_avail = '0;
      sel_used  = '0;
      if (sel_ok) begin
         sel_size  = q_size_o[16*idx +: 16];
         sel_vec   = q_vec_o[16*idx +: 16];
         sel_en    = {15'd0, q_en_o[idx]};
         sel_noff  = qsel;
         sel_desc  = q_desc_o[64*idx +: 64];
         sel_avail = q_avail_o[64*idx +: 64];
         sel_used  = q_used_o[64*idx +: 64];
      end
   end

endmodule

// File: rtl/vq_cfg_regs.sv
module vq_cfg_regs
   import vq_cfg_pkg::*;
#(
   parameter int          ADDR_W    = 6,
   parameter int          NUM_Q     = 4,
   parameter int          MAX_QSIZE = 256,
   parameter int          VEC_TBL   = 64,
   parameter logic [63:0] DEV_FEAT  = 64'hA5A5_0001_3C3C_0F0F
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [1:0]           size,
   input  logic [63:0]          wdata,
   output logic [63:0]          rdata,
   output logic [63:0]          drv_feat_o,
   output logic [7:0]           dev_status_o,
   output logic [15:0]          cfg_vec_o,
   output logic [16*NUM_Q-1:0]  q_size_o,
   output logic [16*NUM_Q-1:0]  q_vec_o,
   output logic [NUM_Q-1:0]     q_en_o,
   output logic [64*NUM_Q-1:0]  q_desc_o,
   output logic [64*NUM_Q-1:0]  q_avail_o,
   output logic [64*NUM_Q-1:0]  q_used_o
);

   initial begin : param_chk
      if (ADDR_W < 6)
         $error("ADDR_W must cover the 56-byte map");
      if (NUM_Q < 2 || NUM_Q > 1024)
         $error("NUM_Q must lie in 2..1024");
      if (MAX_QSIZE < 1 || MAX_QSIZE > 32768 || $countones(MAX_QSIZE) != 1)
         $error("MAX_QSIZE must be a power of two up to 32768");
      if (VEC_TBL < 1 || VEC_TBL > 2048)
         $error("VEC_TBL must lie in 1..2048");
   end

   fld_e        fld;
   fld_e        wfld;
   logic        clr;
   logic [15:0] qsel_q;
   logic [15:0] cvec_q;
   logic [7:0]  stat_q;
   logic [31:0] dsel_q, gsel_q, dfeat_rd, gfeat_rd;
   logic [15:0] s_size, s_vec, s_en, s_noff;
   logic [63:0] s_desc, s_avail, s_used;
   logic [63:0] rmux;

   vq_access_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr (addr),
      .size (size),
      .fld  (fld)
   );

   assign wfld = wr_en ? fld : F_NONE;
   assign clr  = (wfld == F_STAT) && (wdata[7:0] == 8'd0);

   vq_feat_win #(.DEV_FEAT(DEV_FEAT)) u_feat (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .wr_dsel    (wfld == F_DFSEL),
      .wr_gsel    (wfld == F_GFSEL),
      .wr_gfeat   (wfld == F_GFEAT),
      .wdata      (wdata[31:0]),
      .dsel_q     (dsel_q),
      .gsel_q     (gsel_q),
      .dfeat_rd   (dfeat_rd),
      .gfeat_rd   (gfeat_rd),
      .drv_feat_o (drv_feat_o)
   );

   vq_queue_bank #(
      .NUM_Q     (NUM_Q),
      .MAX_QSIZE (MAX_QSIZE),
      .VEC_TBL   (VEC_TBL)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .qsel      (qsel_q),
      .wr_size   (wfld == F_QSIZE),
      .wr_vec    (wfld == F_QVEC),
      .wr_en     (wfld == F_QEN),
      .wr_desc   (wfld == F_QDESC),
      .wr_avail  (wfld == F_QAVAIL),
      .wr_used   (wfld == F_QUSED),
      .wdata     (wdata),
      .sel_size  (s_size),
      .sel_vec   (s_vec),
      .sel_en    (s_en),
      .sel_noff  (s_noff),
      .sel_desc  (s_desc),
      .sel_avail (s_avail),
      .sel_used  (s_used),
      .q_size_o  (q_size_o),
      .q_vec_o   (q_vec_o),
      .q_en_o    (q_en_o),
      .q_desc_o  (q_desc_o),
      .q_avail_o (q_avail_o),
      .q_used_o  (q_used_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qsel_q <= '0;
         cvec_q <= NO_VECTOR;
         stat_q <= '0;
      end else if (clr) begin
         qsel_q <= '0;
         cvec_q <= NO_VECTOR;
         stat_q <= '0;
      end else begin
         if (wfld == F_QSEL) qsel_q <= wdata[15:0];
         if (wfld == F_CVEC) cvec_q <= map_vec(wdata[15:0], VEC_TBL);
         if (wfld == F_STAT) stat_q <= wdata[7:0];
      end
   end

   always_comb begin
      case (fld)
         F_DFSEL:  rmux = {32'd0, dsel_q};
         F_DFEAT:  rmux = {32'd0, dfeat_rd};
         F_GFSEL:  rmux = {32'd0, gsel_q};
         F_GFEAT:  rmux = {32'd0, gfeat_rd};
         F_CVEC:   rmux = {48'd0, cvec_q};
         F_NUMQ:   rmux = {48'd0, 16'(NUM_Q)};
         F_STAT:   rmux = {56'd0, stat_q};
         F_QSEL:   rmux = {48'd0, qsel_q};
         F_QSIZE:  rmux = {48'd0, s_size};
         F_QVEC:   rmux = {48'd0, s_vec};
         F_QEN:    rmux = {48'd0, s_en};
         F_QNOFF:  rmux = {48'd0, s_noff};
         F_QDESC:  rmux = s_desc;
         F_QAVAIL: rmux = s_avail;
         F_QUSED:  rmux = s_used;
         default:  rmux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd_en)
         rdata <= rmux;
   end

   assign dev_status_o = stat_q;
   assign cfg_vec_o    = cvec_q;

endmodule

// File: rtl/vq_cfg_regs_chk.sv
module vq_cfg_regs_chk
   import vq_cfg_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int NUM_Q     = 4,
   parameter int MAX_QSIZE = 256,
   parameter int VEC_TBL   = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [1:0]          size,
   input  logic [7:0]          stat_wdata,
   input  logic [63:0]         rdata,
   input  logic [63:0]         drv_feat_o,
   input  logic [7:0]          dev_status_o,
   input  logic [15:0]         cfg_vec_o,
   input  logic [16*NUM_Q-1:0] q_size_o,
   input  logic [16*NUM_Q-1:0] q_vec_o,
   input  logic [NUM_Q-1:0]    q_en_o,
   input  logic [64*NUM_Q-1:0] q_desc_o,
   input  logic [64*NUM_Q-1:0] q_avail_o,
   input  logic [64*NUM_Q-1:0] q_used_o
);

   logic stat_zero_wr;
   assign stat_zero_wr = wr_en && (addr == ADDR_W'(STAT_OFF)) && (size == 2'd0)
                         && (stat_wdata == 8'd0);

   // R1
   unused_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(6'h15)) |=> (rdata == 64'd0));

   // R7
   cfg_vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_vec_o == NO_VECTOR) || (32'(cfg_vec_o) < VEC_TBL));

   // R10
   status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_zero_wr |=> (dev_status_o == 8'd0 && drv_feat_o == 64'd0
                        && cfg_vec_o == NO_VECTOR && q_en_o == '0));

   // R11
   no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(drv_feat_o) && $stable(dev_status_o) && $stable(cfg_vec_o)
                  && $stable(q_size_o) && $stable(q_vec_o) && $stable(q_en_o)
                  && $stable(q_desc_o) && $stable(q_avail_o) && $stable(q_used_o)));

   genvar q;
   generate
      for (q = 0; q < NUM_Q; q++) begin : g_qchk
         // R5
         qsize_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(q_size_o[16*q +: 16]) <= 1)
            && (32'(q_size_o[16*q +: 16]) <= MAX_QSIZE));
         // R7
         qvec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (q_vec_o[16*q +: 16] == NO_VECTOR) || (32'(q_vec_o[16*q +: 16]) < VEC_TBL));
      end
   endgenerate

endmodule

bind vq_cfg_regs vq_cfg_regs_chk #(
   .ADDR_W    (ADDR_W),
   .NUM_Q     (NUM_Q),
   .MAX_QSIZE (MAX_QSIZE),
   .VEC_TBL   (VEC_TBL)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .rd_en        (rd_en),
   .addr         (addr),
   .size         (size),
   .stat_wdata   (wdata[7:0]),
   .rdata        (rdata),
   .drv_feat_o   (drv_feat_o),
   .dev_status_o (dev_status_o),
   .cfg_vec_o    (cfg_vec_o),
   .q_size_o     (q_size_o),
   .q_vec_o      (q_vec_o),
   .q_en_o       (q_en_o),
   .q_desc_o     (q_desc_o),
   .q_avail_o    (q_avail_o),
   .q_used_o     (q_used_o)
);

// File: tb/vq_cfg_regs_tb.sv
`timescale 1ns/1ps
module vq_cfg_regs_tb;

   localparam int NQ = 4;

   typedef struct packed {
      logic        wr;
      logic [5:0]  a;
      logic [1:0]  sz;
      logic [63:0] d;
      logic [63:0] e;
      logic [7:0]  r;
   } vec_t;

   localparam int NV = 65;
   localparam vec_t TBL [NV] = '{
      '{1'b0, 6'h12, 2'd1, 64'h0, 64'h4, 8'd4},                // R4 queue count
      '{1'b0, 6'h04, 2'd2, 64'h0, 64'h3C3C0F0F, 8'd2},         // R2 low window
      '{1'b1, 6'h00, 2'd2, 64'h1, 64'h0, 8'd2},
      '{1'b0, 6'h04, 2'd2, 64'h0, 64'hA5A50001, 8'd2},         // R2 high window
      '{1'b1, 6'h00, 2'd2, 64'h2, 64'h0, 8'd2},
      '{1'b0, 6'h04, 2'd2, 64'h0, 64'h0, 8'd2},                // R2 select 2
      '{1'b1, 6'h08, 2'd2, 64'h1, 64'h0, 8'd3},
      '{1'b1, 6'h0C, 2'd2, 64'hDEADBEEF, 64'h0, 8'd3},
      '{1'b1, 6'h08, 2'd2, 64'h0, 64'h0, 8'd3},
      '{1'b1, 6'h0C, 2'd2, 64'h12345678, 64'h0, 8'd3},
      '{1'b1, 6'h08, 2'd2, 64'h7, 64'h0, 8'd3},
      '{1'b1, 6'h0C, 2'd2, 64'hFFFFFFFF, 64'h0, 8'd3},         // R3 dropped
      '{1'b0, 6'h0C, 2'd2, 64'h0, 64'h0, 8'd3},                // R3 reads 0
      '{1'b1, 6'h08, 2'd2, 64'h1, 64'h0, 8'd3},
      '{1'b0, 6'h0C, 2'd2, 64'h0, 64'hDEADBEEF, 8'd3},         // R3 high half
      '{1'b1, 6'h08, 2'd2, 64'h0, 64'h0, 8'd3},
      '{1'b0, 6'h0C, 2'd2, 64'h0, 64'h12345678, 8'd3},         // R3 low half
      '{1'b0, 6'h18, 2'd1, 64'h0, 64'h100, 8'd5},              // R5 reset max
      '{1'b1, 6'h18, 2'd1, 64'h64, 64'h0, 8'd5},
      '{1'b0, 6'h18, 2'd1, 64'h0, 64'h100, 8'd5},              // R5 non-pow2
      '{1'b1, 6'h18, 2'd1, 64'h200, 64'h0, 8'd5},
      '{1'b0, 6'h18, 2'd1, 64'h0, 64'h100, 8'd5},              // R5 above max
      '{1'b1, 6'h18, 2'd1, 64'h40, 64'h0, 8'd5},
      '{1'b0, 6'h18, 2'd1, 64'h0, 64'h40, 8'd5},               // R5 lowered
      '{1'b1, 6'h18, 2'd1, 64'h0, 64'h0, 8'd5},
      '{1'b0, 6'h18, 2'd1, 64'h0, 64'h0, 8'd5},                // R5 unused
      '{1'b1, 6'h10, 2'd1, 64'h5, 64'h0, 8'd7},
      '{1'b0, 6'h10, 2'd1, 64'h0, 64'h5, 8'd7},                // R7 valid
      '{1'b1, 6'h10, 2'd1, 64'h40, 64'h0, 8'd7},
      '{1'b0, 6'h10, 2'd1, 64'h0, 64'hFFFF, 8'd7},             // R7 too large
      '{1'b1, 6'h1A, 2'd1, 64'h3F, 64'h0, 8'd7},
      '{1'b0, 6'h1A, 2'd1, 64'h0, 64'h3F, 8'd7},               // R7 top entry
      '{1'b1, 6'h1C, 2'd1, 64'h1, 64'h0, 8'd6},
      '{1'b1, 6'h1C, 2'd1, 64'h2, 64'h0, 8'd6},
      '{1'b0, 6'h1C, 2'd1, 64'h0, 64'h1, 8'd6},                // R6 2 dropped
      '{1'b1, 6'h16, 2'd1, 64'h2, 64'h0, 8'd8},
      '{1'b0, 6'h1E, 2'd1, 64'h0, 64'h2, 8'd4},                // R4 notify off
      '{1'b0, 6'h18, 2'd1, 64'h0, 64'h100, 8'd8},              // R8 bank 2 size
      '{1'b0, 6'h1A, 2'd1, 64'h0, 64'hFFFF, 8'd8},             // R8 bank 2 vec
      '{1'b1, 6'h20, 2'd3, 64'h1122334455667788, 64'h0, 8'd9},
      '{1'b1, 6'h28, 2'd3, 64'hCAFE0000, 64'h0, 8'd9},
      '{1'b0, 6'h20, 2'd3, 64'h0, 64'h1122334455667788, 8'd9}, // R9 desc
      '{1'b0, 6'h28, 2'd3, 64'h0, 64'hCAFE0000, 8'd9},         // R9 avail
      '{1'b1, 6'h16, 2'd1, 64'h5, 64'h0, 8'd8},
      '{1'b0, 6'h18, 2'd1, 64'h0, 64'h0, 8'd8},                // R8 out of range
      '{1'b1, 6'h18, 2'd1, 64'h20, 64'h0, 8'd8},
      '{1'b0, 6'h1E, 2'd1, 64'h0, 64'h0, 8'd8},                // R8 noff 0
      '{1'b0, 6'h20, 2'd3, 64'h0, 64'h0, 8'd8},                // R8 desc 0
      '{1'b1, 6'h16, 2'd1, 64'h2, 64'h0, 8'd8},
      '{1'b0, 6'h18, 2'd1, 64'h0, 64'h100, 8'd8},              // R8 bank 2 intact
      '{1'b0, 6'h12, 2'd2, 64'h0, 64'h0, 8'd1},                // R1 wrong width
      '{1'b1, 6'h10, 2'd2, 64'h7, 64'h0, 8'd1},
      '{1'b0, 6'h10, 2'd1, 64'h0, 64'hFFFF, 8'd1},             // R1 write dropped
      '{1'b0, 6'h15, 2'd0, 64'h0, 64'h0, 8'd1},                // R1 unused byte
      '{1'b0, 6'h20, 2'd2, 64'h0, 64'h0, 8'd1},                // R1 half of 64
      '{1'b1, 6'h00, 2'd2, 64'h0, 64'h0, 8'd4},
      '{1'b1, 6'h04, 2'd2, 64'h0, 64'h0, 8'd4},
      '{1'b0, 6'h04, 2'd2, 64'h0, 64'h3C3C0F0F, 8'd4},         // R4 feat ro
      '{1'b1, 6'h12, 2'd1, 64'h9, 64'h0, 8'd4},
      '{1'b0, 6'h12, 2'd1, 64'h0, 64'h4, 8'd4},                // R4 count ro
      '{1'b1, 6'h14, 2'd0, 64'h0F, 64'h0, 8'd10},
      '{1'b0, 6'h14, 2'd0, 64'h0, 64'h0F, 8'd10},              // R10 status
      '{1'b0, 6'h00, 2'd2, 64'h0, 64'h0, 8'd2},                // R2 select readback
      '{1'b0, 6'h08, 2'd2, 64'h0, 64'h0, 8'd3},                // R3 select readback
      '{1'b0, 6'h38, 2'd3, 64'h0, 64'h0, 8'd1}                 // R1 past map
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic              rd_en = 1'b0;
   logic [5:0]        addr = '0;
   logic [1:0]        size = '0;
   logic [63:0]       wdata = '0;
   logic [63:0]       rdata;
   logic [63:0]       drv_feat_o;
   logic [7:0]        dev_status_o;
   logic [15:0]       cfg_vec_o;
   logic [16*NQ-1:0]  q_size_o;
   logic [16*NQ-1:0]  q_vec_o;
   logic [NQ-1:0]     q_en_o;
   logic [64*NQ-1:0]  q_desc_o;
   logic [64*NQ-1:0]  q_avail_o;
   logic [64*NQ-1:0]  q_used_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   vq_cfg_regs u_dut (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en),
      .addr (addr), .size (size), .wdata (wdata), .rdata (rdata),
      .drv_feat_o (drv_feat_o), .dev_status_o (dev_status_o),
      .cfg_vec_o (cfg_vec_o), .q_size_o (q_size_o), .q_vec_o (q_vec_o),
      .q_en_o (q_en_o), .q_desc_o (q_desc_o), .q_avail_o (q_avail_o),
      .q_used_o (q_used_o)
   );

   task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_wr(input logic [5:0] a, input logic [1:0] sz, input logic [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; size = sz; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic do_rd(input logic [5:0] a, input logic [1:0] sz, output logic [63:0] v);
      @(negedge clk);
      rd_en = 1'b1; addr = a; size = sz;
      @(negedge clk);
      rd_en = 1'b0;
      v = rdata;
   endtask

   initial begin : main
      logic [63:0] v;
      repeat (3) @(negedge clk);
      // reset state, R11 and R7 and R5
      chk("R11 reset rdata", {192'd0, rdata}, 256'd0);
      chk("R5 reset sizes", {192'd0, q_size_o}, {192'd0, {NQ{16'h0100}}});
      chk("R7 reset qvec", {192'd0, q_vec_o}, {192'd0, {NQ{16'hFFFF}}});
      chk("R7 reset cfgvec", {240'd0, cfg_vec_o}, {240'd0, 16'hFFFF});
      chk("R6 reset enable", {252'd0, q_en_o}, 256'd0);
      chk("R3 reset drvfeat", {192'd0, drv_feat_o}, 256'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         if (TBL[i].wr) begin
            do_wr(TBL[i].a, TBL[i].sz, TBL[i].d);
         end else begin
            do_rd(TBL[i].a, TBL[i].sz, v);
            chk($sformatf("R%0d row %0d", TBL[i].r, i), {192'd0, v}, {192'd0, TBL[i].e});
         end
      end

      // R11 outputs in queue order
      chk("R11 q0 size", {240'd0, q_size_o[15:0]}, {240'd0, 16'h0000});
      chk("R11 q2 size", {240'd0, q_size_o[47:32]}, {240'd0, 16'h0100});
      chk("R11 q0 vec", {240'd0, q_vec_o[15:0]}, {240'd0, 16'h003F});
      chk("R11 enables", {252'd0, q_en_o}, {252'd0, 4'b0001});
      chk("R11 q2 desc", {192'd0, q_desc_o[128 +: 64]}, {192'd0, 64'h1122334455667788});
      chk("R11 q2 avail", {192'd0, q_avail_o[128 +: 64]}, {192'd0, 64'hCAFE0000});
      chk("R11 q1 desc", {192'd0, q_desc_o[64 +: 64]}, 256'd0);
      chk("R3 drv feature word", {192'd0, drv_feat_o}, {192'd0, 64'hDEADBEEF12345678});
      chk("R10 status out", {248'd0, dev_status_o}, {248'd0, 8'h0F});

      // R10 zero status resets everything
      do_wr(6'h14, 2'd0, 64'h0);
      chk("R10 clr drvfeat", {192'd0, drv_feat_o}, 256'd0);
      chk("R10 clr cfgvec", {240'd0, cfg_vec_o}, {240'd0, 16'hFFFF});
      chk("R10 clr sizes", {192'd0, q_size_o}, {192'd0, {NQ{16'h0100}}});
      chk("R10 clr qvec", {192'd0, q_vec_o}, {192'd0, {NQ{16'hFFFF}}});
      chk("R10 clr enable", {252'd0, q_en_o}, 256'd0);
      chk("R10 clr desc", q_desc_o, 256'd0);
      chk("R10 clr avail", q_avail_o, 256'd0);
      chk("R10 clr status", {248'd0, dev_status_o}, 256'd0);
      do_rd(6'h16, 2'd1, v);
      chk("R10 clr qsel", {192'd0, v}, 256'd0);
      do_rd(6'h04, 2'd2, v);
      chk("R10 clr dsel", {192'd0, v}, {192'd0, 64'h3C3C0F0F});

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule